// File: doc/BRIEF.md
# Byte-Lane Data Memory with Display Output Register

This block is the data-side memory of a single-cycle 32-bit load/store core. The core presents a byte address, a store value, a write strobe and a 3-bit access code. The load result comes back combinationally in the same cycle, and any store is committed on the rising clock edge. The RAM spans 8 KiB at the bottom of the address space. Byte, halfword and word accesses are steered onto the correct lanes of a little-endian word array. Narrow loads are sign- or zero-extended according to the access code.

One fixed address near the top of the space decodes to a write-only 32-bit register whose value is brought out on a port for a hex display driver. A load from that address returns zero, not the register. Misaligned halfword and word accesses raise no trap: the address bits that the access width does not use are dropped.

Top module: `byte_store_mem`

## Requirements
- R1: RAM answers at byte addresses 0x0000 to 0x1FFF and is little-endian: byte address a holds bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a with its two low bits cleared.
- R2: A load is combinational, so `rd_data` follows `addr` and `acc` within the same cycle. A store becomes visible only after the rising clock edge that samples `wr_en` high.
- R3: Access code 3'b000 loads the addressed byte and copies its bit 7 into bits 31:8.
- R4: Access code 3'b001 loads the halfword chosen by addr[1] (0 selects the low half, 1 the high half) and copies its bit 15 into bits 31:16. addr[0] is ignored.
- R5: Access codes whose two low bits are 2'b10 or 2'b11 are word accesses. A word load returns the whole word and ignores addr[1:0].
- R6: Access code 3'b100 loads the addressed byte and 3'b101 loads the halfword chosen by addr[1]. Both fill the upper bits with zeros.
- R7: A byte store (acc[1:0] = 2'b00) writes wr_data[7:0] into the addressed byte only. The other three bytes of the word are unchanged.
- R8: A halfword store (acc[1:0] = 2'b01) writes wr_data[15:0] into the two bytes of the half chosen by addr[1] only. addr[0] is ignored.
- R9: A word store writes all four bytes of the word with wr_data and ignores addr[1:0].
- R10: A store to 0xFFFFFFFC loads the full 32-bit wr_data into `disp_q`, whatever the access code. Reset clears `disp_q` to zero, and it holds its value in every other cycle.
- R11: A load from 0xFFFFFFFC or from any address at or above 0x2000 returns zero.
- R12: A store to an address that is neither RAM nor 0xFFFFFFFC changes neither RAM nor `disp_q`.
- R13: With `wr_en` low, nothing in RAM or `disp_q` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the display register |
| addr | input | 32 | Byte address of the access |
| wr_data | input | 32 | Store value, low-aligned for narrow stores |
| wr_en | input | 1 | Store strobe |
| acc | input | 3 | Access code: bits 1:0 width (00 byte, 01 half, 1x word), bit 2 zero-extend |
| rd_data | output | 32 | Combinational load result |
| disp_q | output | 32 | Display register contents |

## Verification
The assertions check on every cycle that the display register clears on reset, holds its value unless it is addressed by a store, and takes the full store value when it is. They also check that unmapped and display-address loads read zero and that the extension bits of narrow loads match their access code. Which lane a load picks, and which bytes a narrow store leaves alone, depend on earlier stores. Only the bench's sweeps can show these: they cover every byte offset of a small region with every access code, compared against a byte-level model kept in the bench.

// File: rtl/byte_store_mem.sv
module byte_store_mem #(
  parameter int          RAM_BYTES = 8192,
  parameter logic [31:0] DISP_ADDR = 32'hFFFF_FFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr,
  input  logic [31:0] wr_data,
  input  logic        wr_en,
  input  logic [2:0]  acc,
  output logic [31:0] rd_data,
  output logic [31:0] disp_q
);
  localparam int WORDS = RAM_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0] ram [WORDS];
  logic [31:0] word_q, wlane;
  logic [7:0]  lane_b;
  logic [15:0] lane_h;
  logic [3:0]  be;

  wire              in_ram   = addr < 32'(RAM_BYTES);
  wire              hit_disp = addr == DISP_ADDR;
  wire [IDX_W-1:0]  idx      = addr[IDX_W+1:2];
  wire [1:0]        sz       = acc[1:0];
  wire              uns      = acc[2];

  assign word_q = in_ram ? ram[idx] : '0;
  assign lane_h = addr[1] ? word_q[31:16] : word_q[15:0];

  always_comb begin
    case (addr[1:0])
      2'd0:    lane_b = word_q[7:0];
      2'd1:    lane_b = word_q[15:8];
      2'd2:    lane_b = word_q[23:16];
      default: lane_b = word_q[31:24];
    endcase
  end

  always_comb begin
    case (sz)
      2'b00:   rd_data = {{24{lane_b[7] & ~uns}}, lane_b};
      2'b01:   rd_data = {{16{lane_h[15] & ~uns}}, lane_h};
      default: rd_data = word_q;
    endcase
  end

  always_comb begin
    be = '0;
    case (sz)
      2'b00:   be[addr[1:0]] = 1'b1;
      2'b01:   be = addr[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
  end

  assign wlane = (sz == 2'b00) ? {4{wr_data[7:0]}} :
                 (sz == 2'b01) ? {2{wr_data[15:0]}} : wr_data;

  always_ff @(posedge clk) begin
    if (wr_en && in_ram) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) ram[idx][8*k +: 8] <= wlane[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                disp_q <= '0;
    else if (wr_en && hit_disp) disp_q <= wr_data;
  end
endmodule

module byte_store_mem_chk #(
  parameter int          RAM_BYTES = 8192,
  parameter logic [31:0] DISP_ADDR = 32'hFFFF_FFFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] addr,
  input logic [31:0] wr_data,
  input logic        wr_en,
  input logic [2:0]  acc,
  input logic [31:0] rd_data,
  input logic [31:0] disp_q
);
  AST_DISP_RESET: assert property (@(posedge clk) $rose(rst_n) |-> disp_q == '0); // R10
  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DISP_ADDR) |=> disp_q == $past(wr_data)); // R10
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == DISP_ADDR) |=> $stable(disp_q)); // R13
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 32'(RAM_BYTES)) |-> rd_data == '0); // R11
  AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == 3'b000) |-> rd_data[31:8] == {24{rd_data[7]}}); // R3
  AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == 3'b001) |-> rd_data[31:16] == {16{rd_data[15]}}); // R4
  AST_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == 3'b100 || acc == 3'b101) |-> rd_data[31:16] == '0); // R6
endmodule

bind byte_store_mem byte_store_mem_chk #(.RAM_BYTES(RAM_BYTES), .DISP_ADDR(DISP_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
  .acc(acc), .rd_data(rd_data), .disp_q(disp_q)
);

// File: tb/byte_store_mem_tb.sv
`timescale 1ns/1ps
module byte_store_mem_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] addr = '0, wr_data = '0;
  logic [2:0] acc = 3'b010;
  logic [31:0] rd_data, disp_q;
  int checks = 0, errors = 0;
  logic [7:0] sh [64];

  always #2.5 clk = ~clk;

  byte_store_mem dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .acc(acc), .rd_data(rd_data), .disp_q(disp_q));

  task automatic check(input logic [31:0] act, exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ld_exp(input logic [5:0] a, input logic [2:0] ac);
    logic [5:0] wb = {a[5:2], 2'b00};
    logic [5:0] hb = {a[5:1], 1'b0};
    logic [7:0] b = sh[a];
    logic [15:0] h = {sh[hb + 6'd1], sh[hb]};
    case (ac[1:0])
      2'b00:   return ac[2] ? {24'h0, b} : {{24{b[7]}}, b};
      2'b01:   return ac[2] ? {16'h0, h} : {{16{h[15]}}, h};
      default: return {sh[wb + 6'd3], sh[wb + 6'd2], sh[wb + 6'd1], sh[wb]};
    endcase
  endfunction

  task automatic sh_store(input logic [5:0] a, input logic [31:0] d, input logic [2:0] ac);
    logic [5:0] wb = {a[5:2], 2'b00};
    logic [5:0] hb = {a[5:1], 1'b0};
    case (ac[1:0])
      2'b00: sh[a] = d[7:0];
      2'b01: begin sh[hb] = d[7:0]; sh[hb + 6'd1] = d[15:8]; end
      default: for (int k = 0; k < 4; k++) sh[wb + 6'(k)] = d[8*k +: 8];
    endcase
  endtask

  task automatic wr(input logic [31:0] a, d, input logic [2:0] ac);
    @(negedge clk);
    addr = a; wr_data = d; acc = ac; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 32'd64) sh_store(a[5:0], d, ac);
  endtask

  task automatic rd(input logic [31:0] a, input logic [2:0] ac, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; acc = ac; wr_en = 1'b0;
    #1 check(rd_data, exp, tag);
  endtask

  task automatic sweep_words(input string tag);
    for (int w = 0; w < 16; w++) rd(32'(4*w), 3'b010, ld_exp(6'(4*w), 3'b010), tag);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
    repeat (2) @(negedge clk);
    #1 check(disp_q, 32'h0, "R10 reset");
    rst_n = 1'b1;

    for (int w = 0; w < 16; w++)
      wr(32'(4*w), 32'hF1E2_7384 ^ (32'(w) * 32'h0103_0507), 3'b010);
    for (int a = 0; a < 64; a++)
      for (int c = 0; c < 5; c++)
        rd(32'(a), codes[c], ld_exp(6'(a), codes[c]),
           c == 0 ? "R3 sbyte" : c == 1 ? "R4 shalf" : c == 2 ? "R5 word" : "R6 zext");
    rd(32'd7, 3'b011, ld_exp(6'd4, 3'b010), "R5 code 011");

    for (int a = 0; a < 64; a++)
      wr(32'(a), {24'hABCDEF, 8'(a * 7 + 3)}, a[0] ? 3'b100 : 3'b000);
    sweep_words("R7 byte store");
    for (int a = 0; a < 64; a++) begin
      wr(32'(a), {16'h5A5A, 16'(a * 257 + 32'h8001)}, a[1] ? 3'b101 : 3'b001);
      rd(32'(a & ~32'd3), 3'b010, ld_exp(6'(a & 32'h3C), 3'b010), "R8 half store");
    end
    sweep_words("R8 half lanes");
    for (int a = 0; a < 64; a += 3)
      wr(32'(a), 32'h1234_5678 + 32'(a), 3'b010);
    sweep_words("R9 word store");

    @(negedge clk);
    addr = 32'd8; acc = 3'b010; wr_data = 32'hCAFE_F00D; wr_en = 1'b1;
    #1 check(rd_data, ld_exp(6'd8, 3'b010), "R2 before edge");
    @(posedge clk); #1 check(rd_data, 32'hCAFE_F00D, "R2 after edge");
    @(negedge clk); wr_en = 1'b0; sh_store(6'd8, 32'hCAFE_F00D, 3'b010);

    wr(32'h1FFC, 32'h8765_4321, 3'b010);
    rd(32'h1FFF, 3'b000, 32'hFFFF_FF87, "R1 top byte");
    rd(32'h1FFC, 3'b101, 32'h0000_4321, "R1 top half");
    rd(32'h2000, 3'b010, 32'h0, "R11 past RAM");
    rd(32'h1FFF + 32'd1, 3'b000, 32'h0, "R11 past RAM byte");

    wr(32'hFFFF_FFFC, 32'hDEAD_BEEF, 3'b000);
    rd(32'h0, 3'b010, ld_exp(6'd0, 3'b010), "R12 RAM untouched by disp write");
    check(disp_q, 32'hDEAD_BEEF, "R10 full latch");
    rd(32'hFFFF_FFFC, 3'b010, 32'h0, "R11 disp read");
    wr(32'h0000_2004, 32'h1111_1111, 3'b010);
    wr(32'h8000_0004, 32'h2222_2222, 3'b010);
    wr(32'hFFFF_FFF8, 32'h3333_3333, 3'b010);
    rd(32'h4, 3'b010, ld_exp(6'd4, 3'b010), "R12 no alias");
    check(disp_q, 32'hDEAD_BEEF, "R12 disp kept");

    @(negedge clk);
    addr = 32'hFFFF_FFFC; wr_data = 32'h0; wr_en = 1'b0;
    @(negedge clk); check(disp_q, 32'hDEAD_BEEF, "R13 disp idle");
    addr = 32'd4; acc = 3'b010; wr_data = 32'h0BAD_0BAD;
    @(negedge clk); #1 check(rd_data, ld_exp(6'd4, 3'b010), "R13 RAM idle");

    rst_n = 1'b0;
    #1 check(disp_q, 32'h0, "R10 async clear");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule